// File: doc/BRIEF.md
# Bit-Serial Multiplierless FIR Filter

This block is a fixed-coefficient FIR filter that forms its sum of products without any multiplier. An accepted signed sample is captured into the newest slot of a chain of per-tap word registers. The chain is then walked one bit position per clock, starting at the least significant bit. At each bit position, the current bit from every tap is gathered into a table address. The taps are grouped into partitions. Each partition owns a small constant table whose entry at a given address is the sum of the coefficients whose address bit is set. The partition results are added together. A scaling accumulator then weights that sum by the bit position and adds it. On the sign-bit cycle it subtracts the sum instead, so the result is the exact two's-complement convolution.

A sample is offered with a one-cycle strobe while the filter is idle. The result appears DATA_W+1 clock edges later, together with a one-cycle valid pulse. The next sample may be offered in the same cycle that the valid pulse is high. Coefficients are fixed when the block is elaborated. Taps with a zero coefficient take no part in table addressing.

Top module: `da_fir`

## Requirements
- R1: After reset, yValid is 0, yOut is 0, and every tap history word is 0, so the first result equals coefficient 0 times the first sample.
- R2: Each result equals the exact signed sum over k of COEFS[k] times the sample accepted k samples earlier, for k = 0 to NUM_TAPS-1. Coefficient k occupies bits [k*COEF_W +: COEF_W] of COEFS.
- R3: A sample is accepted at the clock edge where sampleValid is 1 and the filter is idle. yValid is then 1 for exactly one cycle, starting after the DATA_W-th clock edge that follows the accepting edge, and it is 0 in all other cycles.
- R4: While the filter is busy, sampleValid and sampleIn are ignored. Only the value on sampleIn at the accepting edge affects any result.
- R5: A sample offered in the cycle where yValid is 1 is accepted at the next edge, giving a throughput of one sample every DATA_W+1 cycles.
- R6: The sign bit is handled by subtraction, so the results stay exact at the extreme sample values -2^(DATA_W-1) and 2^(DATA_W-1)-1.
- R7: A tap whose coefficient is zero has no effect: the sample sitting at that tap position does not change the result.
- R8: yOut holds its value in every cycle except the one in which a new result is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | DATA_W | Signed input sample |
| sampleValid | input | 1 | Sample offered this cycle |
| yOut | output | OUT_W | Signed filter result, low OUT_W bits of the full-precision sum |
| yValid | output | 1 | One-cycle pulse marking a new yOut |

## Verification
The bench starts with a single sample after reset. This isolates coefficient 0 and shows whether the history was cleared. Random sequences are then driven back to back, with junk strobes and junk data during every busy cycle, to separate correct accumulation from corruption by ignored input. Runs at the most negative and most positive samples expose mistakes in the sign-bit subtraction. Two runs that differ only in the sample at the zero-coefficient tap must give identical results. Idle gaps with changing input show that the output holds its value.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;
  typedef struct packed {
    logic load;   // capture new sample, shift tap chain
    logic shift;  // one bit-serial accumulation step
    logic last;   // current step is the sign bit
  } da_strobe_t;
endpackage

// File: rtl/da_fir_ctrl.sv
module da_fir_ctrl
  import da_fir_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  output da_strobe_t       strobe,
  output logic [BIT_W-1:0] bitIdx
);
  logic busy;
  logic [BIT_W-1:0] bitCnt;

  always_comb begin
    strobe.load  = sampleValid && !busy;
    strobe.shift = busy;
    strobe.last  = busy && (bitCnt == BIT_W'(DATA_W - 1));
  end
  assign bitIdx = bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (strobe.load) begin
      busy   <= 1'b1;
      bitCnt <= '0;
    end else if (busy) begin
      if (strobe.last) busy <= 1'b0;
      else             bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/da_fir_datapath.sv
module da_fir_datapath
  import da_fir_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_TAPS  = 4,
  parameter int COEF_W    = 8,
  parameter int PART_SIZE = 2,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0,
  parameter int OUT_W     = 18,
  localparam int BIT_W     = $clog2(DATA_W),
  localparam int NUM_PARTS = NUM_TAPS / PART_SIZE,
  localparam int TBL_N     = 2 ** PART_SIZE,
  localparam int TBL_W     = COEF_W + $clog2(PART_SIZE) + 1,
  localparam int ACC_W     = DATA_W + COEF_W + $clog2(NUM_TAPS) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  da_strobe_t       strobe,
  input  logic [BIT_W-1:0] bitIdx,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [OUT_W-1:0] yOut,
  output logic             yValid
);
  function automatic logic signed [COEF_W-1:0] coefAt(int k);
    return COEFS[k*COEF_W +: COEF_W];
  endfunction

  function automatic logic signed [TBL_W-1:0] partSum(int p, int a);
    logic signed [TBL_W-1:0] s;
    s = '0;
    for (int j = 0; j < PART_SIZE; j++)
      if (a[j]) s = s + TBL_W'(coefAt(p*PART_SIZE + j));
    return s;
  endfunction

  logic [DATA_W-1:0] tapReg [NUM_TAPS];
  logic [NUM_TAPS-1:0] addrBit;
  logic signed [TBL_W-1:0] tbl [NUM_PARTS][TBL_N];
  logic signed [TBL_W-1:0] partOut [NUM_PARTS];
  logic signed [ACC_W-1:0] sumAll, weighted, acc, accNext;

  // tap chain: load shifts samples, bit steps rotate each word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_TAPS; k++) tapReg[k] <= '0;
    end else if (strobe.load) begin
      tapReg[0] <= sampleIn;
      for (int k = 1; k < NUM_TAPS; k++) tapReg[k] <= tapReg[k-1];
    end else if (strobe.shift) begin
      for (int k = 0; k < NUM_TAPS; k++)
        tapReg[k] <= {tapReg[k][0], tapReg[k][DATA_W-1:1]};
    end
  end

  // zero-coefficient taps are dropped from the address
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_addr
    if (COEFS[k*COEF_W +: COEF_W] == '0) begin : g_zero
      assign addrBit[k] = 1'b0;
    end else begin : g_live
      assign addrBit[k] = tapReg[k][0];
    end
  end

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    for (genvar a = 0; a < TBL_N; a++) begin : g_ent
      assign tbl[p][a] = partSum(p, a);
    end
    assign partOut[p] = tbl[p][addrBit[p*PART_SIZE +: PART_SIZE]];
  end

  always_comb begin
    sumAll = '0;
    for (int p = 0; p < NUM_PARTS; p++)
      sumAll = sumAll + {{(ACC_W-TBL_W){partOut[p][TBL_W-1]}}, partOut[p]};
    weighted = sumAll <<< bitIdx;
    accNext  = strobe.last ? acc - weighted : acc + weighted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      yOut   <= '0;
      yValid <= 1'b0;
    end else begin
      yValid <= strobe.shift && strobe.last;
      if (strobe.load)       acc <= '0;
      else if (strobe.shift) acc <= accNext;
      if (strobe.shift && strobe.last) yOut <= accNext[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/da_fir.sv
module da_fir
  import da_fir_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_TAPS  = 4,
  parameter int COEF_W    = 8,
  parameter int PART_SIZE = 2,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = 32'h0700FB03,
  parameter int OUT_W     = DATA_W + COEF_W + $clog2(NUM_TAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              sampleValid,
  output logic [OUT_W-1:0]  yOut,
  output logic              yValid
);
  localparam int BIT_W = $clog2(DATA_W);
  da_strobe_t strobe;
  logic [BIT_W-1:0] bitIdx;

  da_fir_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .strobe(strobe), .bitIdx(bitIdx)
  );

  da_fir_datapath #(
    .DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W),
    .PART_SIZE(PART_SIZE), .COEFS(COEFS), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIdx(bitIdx),
    .sampleIn(sampleIn), .yOut(yOut), .yValid(yValid)
  );
endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk #(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic [OUT_W-1:0] yOut,
  input logic             yValid
);
  localparam int CNT_W = $clog2(DATA_W + 1) + 1;
  logic [CNT_W-1:0] cnt;
  logic dueNow;

  // independent count of bit cycles since each accepted sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      dueNow <= 1'b0;
    end else begin
      dueNow <= (cnt == CNT_W'(1));
      if (cnt == '0) begin
        if (sampleValid) cnt <= CNT_W'(DATA_W);
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!yValid && yOut == '0));
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    yValid |=> !yValid);
  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_W'(1)) |=> yValid);
  p_only_when_due_r3: assert property (@(posedge clk) disable iff (!rstN)
    yValid |-> dueNow);
  p_hold_output_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != CNT_W'(1)) |=> $stable(yOut));
endmodule

bind da_fir da_fir_chk #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
  .yOut(yOut), .yValid(yValid)
);

// File: tb/da_fir_tb.sv
module da_fir_tb;
  localparam int DATA_W = 8;
  localparam int OUT_W  = 18;
  localparam int NT     = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DATA_W-1:0] sampleIn = '0;
  logic sampleValid = 1'b0;
  logic [OUT_W-1:0] yOut;
  logic yValid;

  int checks = 0;
  int fails = 0;
  int hist [NT];
  int coef [NT] = '{3, -5, 0, 7};
  bit done = 0;

  always #10 clk = ~clk;

  da_fir u_dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .yOut(yOut), .yValid(yValid)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    sampleValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < NT; k++) hist[k] = 0;
  endtask

  function automatic int model();
    int s = 0;
    for (int k = 0; k < NT; k++) s += coef[k] * hist[k];
    return s;
  endfunction

  // called at a negedge; returns at the negedge after the result pulse
  task automatic pushSample(string req, int x, bit junk, output int res);
    sampleIn = DATA_W'(x);
    sampleValid = 1'b1;
    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    @(posedge clk);
    for (int i = 0; i < DATA_W; i++) begin
      @(negedge clk);
      if (i == DATA_W - 1) check("R3 no early valid", int'(yValid), 0);
      sampleValid = junk;   // R4: ignored while busy
      sampleIn = DATA_W'($urandom);
      @(posedge clk);
    end
    @(negedge clk);
    sampleValid = 1'b0;
    check("R3 valid pulse", int'(yValid), 1);
    res = int'($signed(yOut));
    check(req, res, model());
  endtask

  task automatic testReset();
    int r;
    doReset();
    check("R1 yValid after reset", int'(yValid), 0);
    check("R1 yOut after reset", int'(yOut), 0);
    pushSample("R1 first result uses cleared history", 10, 1'b0, r);
    check("R1 first result value", r, 30);
  endtask

  task automatic testRandom();
    int r;
    doReset();
    for (int n = 0; n < 40; n++)
      pushSample("R2/R4/R5 back-to-back random with junk", $signed(8'($urandom)), 1'b1, r);
  endtask

  task automatic testExtremes();
    int r;
    doReset();
    for (int n = 0; n < 4; n++) pushSample("R6 most negative", -128, 1'b1, r);
    check("R6 steady -128", r, -640);
    for (int n = 0; n < 4; n++) pushSample("R6 most positive", 127, 1'b1, r);
    check("R6 steady 127", r, 635);
    pushSample("R6 alternating", -128, 1'b0, r);
    pushSample("R6 alternating", 127, 1'b0, r);
  endtask

  task automatic testZeroTap();
    int a, b, r;
    doReset();
    pushSample("R7 run A", 11, 1'b0, r);
    pushSample("R7 run A", 20, 1'b0, r);
    pushSample("R7 run A", 30, 1'b0, a);
    doReset();
    pushSample("R7 run B", -77, 1'b0, r);
    pushSample("R7 run B", 20, 1'b0, r);
    pushSample("R7 run B", 30, 1'b0, b);
    check("R7 zero-coefficient tap has no effect", b, a);
  endtask

  task automatic testHold();
    int r, held;
    doReset();
    pushSample("R8 before gap", -42, 1'b0, r);
    held = int'(yOut);
    for (int i = 0; i < 6; i++) begin
      sampleIn = DATA_W'($urandom);
      @(negedge clk);
    end
    check("R8 yOut held in idle gap", int'(yOut), held);
    check("R8 yValid low in idle gap", int'(yValid), 0);
    pushSample("R2 after gap", 55, 1'b1, r);
  endtask

  initial begin
    testReset();
    testRandom();
    testExtremes();
    testZeroTap();
    testHold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule